// File: doc/BRIEF.md
# Serial Register Access Master

This block reads and writes 32-bit registers in up to four addressed slave devices over a serial link at 8N1 framing. A request carries a slave index, a 7-bit register number, a read/write flag and, for writes, a 32-bit value. When the block accepts a request, it builds a frame and appends a CRC-8. It then shifts the frame out on `txLine` at the configured baud rate.

A write ends once the last bit has been sent. A read hands over to a receiver that captures a fixed eight-byte reply. Each of the two phases has its own timeout, counted in milliseconds from a tick input. A receive timeout marks the slave in a not-found mask, and that mark stays set until reset. Software or a sequencer drives the request pins and watches the done and timeout pulses. It reads the captured reply while `rxDone` is high.

Top module: `regLinkMaster`

## Requirements
- R1: Every frame starts with three header bytes in this order: sync 0xA0, the slave index zero-extended to a byte, and (register[6:0] << 1) | write, where write = 1 for a write.
- R2: A write frame is 8 bytes: the header, then the 32-bit data most significant byte first, then the CRC.
- R3: A read frame is 4 bytes: the header followed by the CRC.
- R4: The CRC starts at 0 and covers every byte before it in the frame. Each byte is fed least significant bit first. For each bit, if (crc[7] XOR bit) the result is (crc << 1) XOR 0x07, otherwise crc << 1.
- R5: `txLine` idles high. Each byte is one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts CLK_HZ/BAUD clock cycles, and the bytes of a frame follow one another.
- R6: After a write frame's last stop bit, `linkState` goes to TX_READY (2) for exactly one cycle with `txDone` high, then to IDLE (0). No reply is awaited. The other state codes are TX = 1, RX = 3 and RX_READY = 4.
- R7: After a read frame, the block enters RX (3) and captures exactly 8 reply bytes. Reply byte i appears at `replyData[8i+7:8i]`. Then RX_READY (4) lasts one cycle with `rxDone` high, followed by IDLE.
- R8: A request is accepted (`reqAccept`) only in IDLE. In any other state, `reqReject` is raised and the transaction in progress is unaffected.
- R9: A request whose register number has bit 7 set is rejected in every state. It sends nothing and leaves the state unchanged.
- R10: If TIMEOUT_MS+1 ticks arrive during TX, the frame is abandoned on the last of them. `timeoutTx` pulses for one cycle, the state returns to IDLE and `txLine` returns high.
- R11: If TIMEOUT_MS+1 ticks arrive during RX, `timeoutRx` pulses for one cycle, the state returns to IDLE, and bit [slave] of `notFound` is set.
- R12: `notFound` bits are only ever set and are cleared only by reset. After reset, the state is IDLE, `txLine` is high and `notFound` is 0.
- R13: The phase tick count restarts when RX begins, so ticks received during TX do not count toward the receive timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse per millisecond |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSlave | input | SLAVE_W | Slave index |
| reqReg | input | 8 | Register number; bit 7 set means invalid |
| reqData | input | 32 | Write data |
| reqAccept | output | 1 | Request taken this cycle |
| reqReject | output | 1 | Request refused this cycle |
| txLine | output | 1 | Serial transmit line |
| rxLine | input | 1 | Serial receive line |
| linkState | output | 3 | Transaction state code |
| txDone | output | 1 | Write transmitted (one cycle) |
| rxDone | output | 1 | Reply captured (one cycle) |
| timeoutTx | output | 1 | Transmit phase timed out (one cycle) |
| timeoutRx | output | 1 | Receive phase timed out (one cycle) |
| replyData | output | 64 | Captured reply bytes |
| notFound | output | NUM_SLAVES | Sticky per-slave no-answer mask |

## Verification
The bench decodes `txLine` bit by bit and compares the frames byte for byte. Getting the data byte order or the CRC bit order wrong shows up as a wrong byte, and a read that sends the write length shows up as a wrong byte count. It sends exactly TIMEOUT_MS ticks in a phase and checks that the state holds, then sends one more and checks the abort. An off-by-one timer aborts one tick early or one tick late. Ticks sent during TX ahead of a read test the timer restart, since a timer that keeps counting would raise the receive timeout early. The bench also checks refusals while busy, the bit-7 rejection, a reply placed in reverse order, and whether a later successful read to the same slave clears its `notFound` bit.

// File: rtl/regLinkPkg.sv
package regLinkPkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_TX       = 3'd1,
    ST_TX_READY = 3'd2,
    ST_RX       = 3'd3,
    ST_RX_READY = 3'd4
  } linkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch request and start sending
    logic abort;     // drop the frame in flight
    logic rxStart;   // clear the reply byte counter
    logic rxEnable;  // receiver armed
  } dpStrobe_t;

  localparam logic [7:0] SYNC_BYTE   = 8'hA0;
  localparam logic [7:0] CRC_POLY    = 8'h07;
  localparam int         REPLY_BYTES = 8;

  function automatic logic [7:0] crc8Byte(input logic [7:0] crcIn, input logic [7:0] dataIn);
    logic [7:0] c;
    c = crcIn;
    for (int j = 0; j < 8; j++) begin
      if (c[7] ^ dataIn[j]) c = {c[6:0], 1'b0} ^ CRC_POLY;
      else                  c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/regLinkUartTx.sv
module regLinkUartTx #(
  parameter int DIV = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       abort,
  input  logic       start,
  input  logic [7:0] data,
  output logic       busy,
  output logic       byteDone,
  output logic       line
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [9:0]       shiftQ;
  logic [3:0]       bitQ;
  logic [CNT_W-1:0] divQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ   <= '1;
      bitQ     <= '0;
      divQ     <= '0;
      busy     <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (!busy && start) begin
        shiftQ <= {1'b1, data, 1'b0};
        busy   <= 1'b1;
        divQ   <= '0;
        bitQ   <= '0;
      end else if (busy) begin
        if (divQ == CNT_W'(DIV - 1)) begin
          divQ <= '0;
          if (bitQ == 4'd9) begin
            busy     <= 1'b0;
            byteDone <= 1'b1;
          end else begin
            bitQ   <= bitQ + 4'd1;
            shiftQ <= {1'b1, shiftQ[9:1]};
          end
        end else begin
          divQ <= divQ + 1'b1;
        end
      end
    end
  end

  assign line = busy ? shiftQ[0] : 1'b1;

endmodule

// File: rtl/regLinkUartRx.sv
module regLinkUartRx #(
  parameter int DIV = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       line,
  output logic       valid,
  output logic [7:0] data
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF  = (DIV / 2 > 0) ? DIV / 2 : 1;

  logic             syncA, syncB;
  logic             activeQ;
  logic [CNT_W-1:0] cntQ;
  logic [3:0]       bitQ;
  logic [7:0]       shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= line;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      activeQ <= 1'b0;
      cntQ    <= '0;
      bitQ    <= '0;
      shiftQ  <= '0;
      valid   <= 1'b0;
      data    <= '0;
    end else begin
      valid <= 1'b0;
      if (!activeQ) begin
        if (!syncB) begin
          activeQ <= 1'b1;
          cntQ    <= CNT_W'(HALF - 1);
          bitQ    <= '0;
        end
      end else if (cntQ == '0) begin
        cntQ <= CNT_W'(DIV - 1);
        if (bitQ == 4'd0) begin
          if (syncB) activeQ <= 1'b0;   // glitch, not a start bit
          else       bitQ    <= 4'd1;
        end else if (bitQ <= 4'd8) begin
          shiftQ <= {syncB, shiftQ[7:1]};
          bitQ   <= bitQ + 4'd1;
        end else begin
          activeQ <= 1'b0;
          if (syncB) begin
            valid <= 1'b1;
            data  <= shiftQ;
          end
        end
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

endmodule

// File: rtl/regLinkDatapath.sv
module regLinkDatapath
  import regLinkPkg::*;
#(
  parameter int DIV     = 10,
  parameter int SLAVE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic               reqWrite,
  input  logic [SLAVE_W-1:0] reqSlave,
  input  logic [6:0]         reqRegNum,
  input  logic [31:0]        reqData,
  input  logic               rxLine,
  output logic               txLine,
  output logic               txAllDone,
  output logic               rxAllDone,
  output logic [63:0]        replyData
);
  localparam int FRAME_MAX = 8;

  logic [7:0] frameBuf  [FRAME_MAX];
  logic [7:0] nextFrame [FRAME_MAX];
  logic [2:0] txIdx, lastIdx;
  logic       txKick, txActive;
  logic [3:0] rxCount;
  logic       txBusy, txByteDone, rxValid;
  logic [7:0] rxByte;
  logic [7:0] crcRead, crcWrite;

  // frame assembly with CRC over the preceding bytes
  always_comb begin
    nextFrame[0] = SYNC_BYTE;
    nextFrame[1] = {{(8 - SLAVE_W){1'b0}}, reqSlave};
    nextFrame[2] = {reqRegNum, reqWrite};
    crcRead = '0;
    for (int i = 0; i < 3; i++) crcRead = crc8Byte(crcRead, nextFrame[i]);
    crcWrite = crcRead;
    for (int i = 0; i < 4; i++) crcWrite = crc8Byte(crcWrite, reqData[31 - 8*i -: 8]);
    for (int i = 3; i < FRAME_MAX; i++) nextFrame[i] = '0;
    if (reqWrite) begin
      for (int i = 0; i < 4; i++) nextFrame[3 + i] = reqData[31 - 8*i -: 8];
      nextFrame[7] = crcWrite;
    end else begin
      nextFrame[3] = crcRead;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FRAME_MAX; i++) frameBuf[i] <= '0;
      txIdx     <= '0;
      lastIdx   <= '0;
      txKick    <= 1'b0;
      txActive  <= 1'b0;
      txAllDone <= 1'b0;
    end else begin
      txAllDone <= 1'b0;
      if (strobe.abort) begin
        txKick   <= 1'b0;
        txActive <= 1'b0;
      end else if (strobe.load) begin
        frameBuf <= nextFrame;
        lastIdx  <= reqWrite ? 3'd7 : 3'd3;
        txIdx    <= '0;
        txKick   <= 1'b1;
        txActive <= 1'b1;
      end else begin
        if (txKick && !txBusy) txKick <= 1'b0;
        if (txByteDone) begin
          if (txIdx == lastIdx) begin
            txActive  <= 1'b0;
            txAllDone <= 1'b1;
          end else begin
            txIdx  <= txIdx + 3'd1;
            txKick <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCount   <= '0;
      replyData <= '0;
      rxAllDone <= 1'b0;
    end else begin
      rxAllDone <= 1'b0;
      if (strobe.rxStart) begin
        rxCount <= '0;
      end else if (rxValid && strobe.rxEnable && rxCount < 4'(REPLY_BYTES)) begin
        replyData[{rxCount[2:0], 3'b000} +: 8] <= rxByte;
        rxCount <= rxCount + 4'd1;
        if (rxCount == 4'(REPLY_BYTES - 1)) rxAllDone <= 1'b1;
      end
    end
  end

  regLinkUartTx #(.DIV(DIV)) uTx (
    .clk(clk), .rstN(rstN), .abort(strobe.abort), .start(txKick),
    .data(frameBuf[txIdx]), .busy(txBusy), .byteDone(txByteDone), .line(txLine)
  );

  regLinkUartRx #(.DIV(DIV)) uRx (
    .clk(clk), .rstN(rstN), .enable(strobe.rxEnable), .line(rxLine),
    .valid(rxValid), .data(rxByte)
  );

  // R5: the line stays high whenever no frame is being sent
  a_r5_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |-> txLine);

  // R7: never more than the fixed reply length is captured
  a_r7_reply_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= 4'(REPLY_BYTES));

endmodule

// File: rtl/regLinkCtrl.sv
module regLinkCtrl
  import regLinkPkg::*;
#(
  parameter int NUM_SLAVES = 4,
  parameter int SLAVE_W    = 2,
  parameter int TIMEOUT_MS = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  msTick,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [SLAVE_W-1:0]    reqSlave,
  input  logic                  reqRegMsb,
  input  logic                  txAllDone,
  input  logic                  rxAllDone,
  output dpStrobe_t             strobe,
  output logic                  reqAccept,
  output logic                  reqReject,
  output logic [2:0]            linkState,
  output logic                  txDone,
  output logic                  rxDone,
  output logic                  timeoutTx,
  output logic                  timeoutRx,
  output logic [NUM_SLAVES-1:0] notFound
);
  localparam int TW = $clog2(TIMEOUT_MS + 1);

  linkState_e         stateQ;
  logic [TW-1:0]      timerQ;
  logic               isReadQ;
  logic [SLAVE_W-1:0] slaveQ;
  logic               phaseExpired;

  assign reqAccept    = reqValid && (stateQ == ST_IDLE) && !reqRegMsb;
  assign reqReject    = reqValid && !reqAccept;
  assign phaseExpired = msTick && (timerQ == TW'(TIMEOUT_MS));

  always_comb begin
    strobe.load     = reqAccept;
    strobe.abort    = (stateQ == ST_TX) && !txAllDone && phaseExpired;
    strobe.rxStart  = (stateQ == ST_TX) && txAllDone && isReadQ;
    strobe.rxEnable = (stateQ == ST_RX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      timerQ    <= '0;
      isReadQ   <= 1'b0;
      slaveQ    <= '0;
      notFound  <= '0;
      timeoutTx <= 1'b0;
      timeoutRx <= 1'b0;
    end else begin
      timeoutTx <= 1'b0;
      timeoutRx <= 1'b0;
      case (stateQ)
        ST_IDLE: if (reqAccept) begin
          stateQ  <= ST_TX;
          timerQ  <= '0;
          isReadQ <= !reqWrite;
          slaveQ  <= reqSlave;
        end
        ST_TX: if (txAllDone) begin
          stateQ <= isReadQ ? ST_RX : ST_TX_READY;
          timerQ <= '0;
        end else if (phaseExpired) begin
          stateQ    <= ST_IDLE;
          timeoutTx <= 1'b1;
        end else if (msTick) begin
          timerQ <= timerQ + 1'b1;
        end
        ST_RX: if (rxAllDone) begin
          stateQ <= ST_RX_READY;
        end else if (phaseExpired) begin
          stateQ           <= ST_IDLE;
          timeoutRx        <= 1'b1;
          notFound[slaveQ] <= 1'b1;
        end else if (msTick) begin
          timerQ <= timerQ + 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign linkState = stateQ;
  assign txDone    = (stateQ == ST_TX_READY);
  assign rxDone    = (stateQ == ST_RX_READY);

  // R6: completion state lasts one cycle
  a_r6_txready_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_TX_READY) |=> (stateQ == ST_IDLE));

  // R7: reply state lasts one cycle
  a_r7_rxready_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RX_READY) |=> (stateQ == ST_IDLE));

  // R8: an accepted request always starts transmission
  a_r8_accept_starts_tx: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |=> (stateQ == ST_TX));

  // R11: a receive timeout leaves the block idle with the slave marked
  a_r11_timeout_marks: assert property (@(posedge clk) disable iff (!rstN)
    timeoutRx |-> (stateQ == ST_IDLE) && notFound[slaveQ]);

  // R12: mask bits never fall outside reset
  a_r12_mask_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (notFound & $past(notFound)) == $past(notFound));

endmodule

// File: rtl/regLinkMaster.sv
module regLinkMaster
  import regLinkPkg::*;
#(
  parameter int CLK_HZ     = 72_000_000,
  parameter int BAUD       = 256_000,
  parameter int NUM_SLAVES = 4,
  parameter int TIMEOUT_MS = 20,
  localparam int DIV       = CLK_HZ / BAUD,
  localparam int SLAVE_W   = $clog2(NUM_SLAVES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  msTick,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [SLAVE_W-1:0]    reqSlave,
  input  logic [7:0]            reqReg,
  input  logic [31:0]           reqData,
  output logic                  reqAccept,
  output logic                  reqReject,
  output logic                  txLine,
  input  logic                  rxLine,
  output logic [2:0]            linkState,
  output logic                  txDone,
  output logic                  rxDone,
  output logic                  timeoutTx,
  output logic                  timeoutRx,
  output logic [63:0]           replyData,
  output logic [NUM_SLAVES-1:0] notFound
);
  dpStrobe_t strobe;
  logic      txAllDone, rxAllDone;

  regLinkCtrl #(
    .NUM_SLAVES(NUM_SLAVES), .SLAVE_W(SLAVE_W), .TIMEOUT_MS(TIMEOUT_MS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .msTick(msTick), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqSlave(reqSlave), .reqRegMsb(reqReg[7]),
    .txAllDone(txAllDone), .rxAllDone(rxAllDone), .strobe(strobe),
    .reqAccept(reqAccept), .reqReject(reqReject), .linkState(linkState),
    .txDone(txDone), .rxDone(rxDone), .timeoutTx(timeoutTx),
    .timeoutRx(timeoutRx), .notFound(notFound)
  );

  regLinkDatapath #(.DIV(DIV), .SLAVE_W(SLAVE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqSlave(reqSlave), .reqRegNum(reqReg[6:0]), .reqData(reqData),
    .rxLine(rxLine), .txLine(txLine), .txAllDone(txAllDone),
    .rxAllDone(rxAllDone), .replyData(replyData)
  );

endmodule

// File: tb/tb_regLinkMaster.sv
module tb_regLinkMaster;
  localparam int CLK_HZ = 2_560_000;
  localparam int BAUD   = 256_000;
  localparam int DIV    = CLK_HZ / BAUD;
  localparam int TMO    = 20;

  logic        clk = 0, rstN = 0, msTick = 0, reqValid = 0, reqWrite = 0;
  logic [1:0]  reqSlave = 0;
  logic [7:0]  reqReg = 0;
  logic [31:0] reqData = 0;
  logic        rxLine = 1;
  logic        reqAccept, reqReject, txLine, txDone, rxDone, timeoutTx, timeoutRx;
  logic [2:0]  linkState;
  logic [63:0] replyData;
  logic [3:0]  notFound;

  int checks = 0, fails = 0;
  int monCount = 0;
  logic [7:0] monBytes [16];
  logic [7:0] monShift;

  always #2 clk = ~clk;

  regLinkMaster #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .NUM_SLAVES(4), .TIMEOUT_MS(TMO)) dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSlave(reqSlave), .reqReg(reqReg), .reqData(reqData), .reqAccept(reqAccept),
    .reqReject(reqReject), .txLine(txLine), .rxLine(rxLine), .linkState(linkState),
    .txDone(txDone), .rxDone(rxDone), .timeoutTx(timeoutTx), .timeoutRx(timeoutRx),
    .replyData(replyData), .notFound(notFound)
  );

  // line monitor: decode 8N1 bytes from txLine
  initial forever begin
    @(negedge clk);
    if (rstN && txLine == 1'b0) begin
      repeat (DIV/2) @(negedge clk);
      for (int b = 0; b < 8; b++) begin
        repeat (DIV) @(negedge clk);
        monShift[b] = txLine;
      end
      repeat (DIV) @(negedge clk);
      if (monCount < 16) monBytes[monCount] = monShift;
      monCount++;
    end
  end

  function automatic logic [7:0] refCrc(input logic [7:0] bytes [8], input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++)
        c = (c[7] ^ bytes[i][j]) ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
    return c;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [1:0] s, input logic [7:0] r,
                       input logic [31:0] d, output logic acc, output logic rej);
    @(negedge clk);
    reqValid = 1; reqWrite = w; reqSlave = s; reqReg = r; reqData = d;
    #1;
    acc = reqAccept; rej = reqReject;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic tick();
    msTick = 1;
    @(negedge clk);
    msTick = 0;
  endtask

  task automatic waitState(input logic [2:0] st, input int maxCycles, output logic seen);
    seen = 0;
    for (int i = 0; i < maxCycles && !seen; i++) begin
      @(negedge clk);
      if (linkState == st) seen = 1;
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxLine = 0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (DIV) @(negedge clk);
    end
    rxLine = 1;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic checkFrame(input string tag, input logic [7:0] exp [8], input int n);
    check({tag, " byte count"}, 64'(monCount), 64'(n));
    for (int i = 0; i < n; i++) check(tag, 64'(monBytes[i]), 64'(exp[i]));
  endtask

  task automatic testReset();
    check("R12 reset state", 64'(linkState), 64'd0);
    check("R12 reset line", 64'(txLine), 64'd1);
    check("R12 reset mask", 64'(notFound), 64'd0);
    check("R6 R7 reset done", 64'({txDone, rxDone}), 64'd0);
  endtask

  task automatic testWrite();
    logic acc, rej, seen;
    logic [7:0] exp [8];
    monCount = 0;
    issue(1, 2'd2, 8'h15, 32'hDEADBEEF, acc, rej);
    check("R8 write accepted", 64'({acc, rej}), 64'b10);
    issue(0, 2'd1, 8'h01, 32'h0, acc, rej);            // refused while busy (R8)
    check("R8 busy reject", 64'({acc, rej}), 64'b01);
    check("R8 state kept", 64'(linkState), 64'd1);
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (txDone) seen = 1;
    end
    check("R6 txDone seen", 64'(seen), 64'd1);
    check("R6 TX_READY code", 64'(linkState), 64'd2);
    @(negedge clk);
    check("R6 one cycle", 64'({txDone, linkState}), 64'd0);
    exp = '{8'hA0, 8'h02, 8'h2B, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h00};
    exp[7] = refCrc(exp, 7);
    checkFrame("R1 R2 R4 R5 write frame", exp, 8);
    repeat (150) @(negedge clk);
    check("R6 no reply phase", 64'({monCount[7:0], linkState}), {53'd0, 8'd8, 3'd0});
  endtask

  task automatic testBadReg();
    logic acc, rej;
    monCount = 0;
    issue(0, 2'd1, 8'h85, 32'h0, acc, rej);
    check("R9 bit7 reject", 64'({acc, rej}), 64'b01);
    repeat (60) @(negedge clk);
    check("R9 no frame", 64'(monCount), 64'd0);
    check("R9 state idle", 64'(linkState), 64'd0);
  endtask

  task automatic doRead(input string tag, input logic [1:0] s, input logic [7:0] r,
                        input logic [63:0] reply);
    logic acc, rej, seen;
    logic [7:0] exp [8];
    monCount = 0;
    issue(0, s, r, 32'h0, acc, rej);
    check({tag, " R8 accept"}, 64'(acc), 64'd1);
    waitState(3'd3, 2000, seen);
    check({tag, " R7 enters RX"}, 64'(seen), 64'd1);
    exp = '{8'hA0, {6'd0, s}, {r[6:0], 1'b0}, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    exp[3] = refCrc(exp, 3);
    checkFrame({tag, " R1 R3 R4 read frame"}, exp, 4);
    issue(1, 2'd0, 8'h02, 32'h1, acc, rej);            // refused during RX (R8)
    check({tag, " R8 reject in RX"}, 64'({acc, rej}), 64'b01);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 8; i++) sendByte(reply[8*i +: 8]);
    seen = 0;
    for (int i = 0; i < 50 && !seen; i++) begin
      if (rxDone) seen = 1;
      else @(negedge clk);
    end
    check({tag, " R7 rxDone"}, 64'({seen, linkState}), {60'd0, 1'b1, 3'd4});
    check({tag, " R7 reply order"}, replyData, reply);
    @(negedge clk);
    check({tag, " R7 back to idle"}, 64'({rxDone, linkState}), 64'd0);
  endtask

  task automatic readTimeout(input string tag, input logic [1:0] s, input logic [3:0] expMask);
    logic acc, rej, seen;
    issue(0, s, 8'h10, 32'h0, acc, rej);
    for (int i = 0; i < 15; i++) begin               // ticks during TX (R13)
      tick();
      repeat (8) @(negedge clk);
    end
    check({tag, " R13 still TX"}, 64'(linkState), 64'd1);
    waitState(3'd3, 2000, seen);
    check({tag, " R13 in RX"}, 64'(seen), 64'd1);
    for (int i = 0; i < TMO; i++) tick();
    check({tag, " R11 R13 holds at limit"}, 64'({timeoutRx, linkState}), 64'd3);
    tick();
    check({tag, " R11 timeout"}, 64'({timeoutRx, linkState}), {60'd0, 1'b1, 3'd0});
    check({tag, " R11 mask"}, 64'(notFound), 64'(expMask));
    @(negedge clk);
    check({tag, " R11 pulse width"}, 64'(timeoutRx), 64'd0);
  endtask

  task automatic txTimeout();
    logic acc, rej;
    issue(1, 2'd0, 8'h22, 32'h12345678, acc, rej);
    for (int i = 0; i < TMO; i++) tick();
    check("R10 holds at limit", 64'({timeoutTx, linkState}), 64'd1);
    tick();
    check("R10 timeout", 64'({timeoutTx, linkState, txLine}), {59'd0, 1'b1, 3'd0, 1'b1});
    check("R10 mask untouched", 64'(notFound), 64'b1000);
    @(negedge clk);
    check("R10 pulse width", 64'(timeoutTx), 64'd0);
    repeat (200) @(negedge clk);
    check("R10 line idle", 64'(txLine), 64'd1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1;
    repeat (3) @(negedge clk);
    testWrite();
    testBadReg();
    doRead("read1", 2'd1, 8'h06, 64'h8877665544332211);
    readTimeout("to3", 2'd3, 4'b1000);
    txTimeout();
    doRead("read3", 2'd3, 8'h7F, 64'h0123456789ABCDEF);
    check("R12 sticky after good read", 64'(notFound), 64'b1000);
    readTimeout("to0", 2'd0, 4'b1001);
    check("R12 mask accumulates", 64'(notFound), 64'b1001);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule